// File: doc/BRIEF.md
# Multi-Lane Serial Flash Burst Reader

This block sits on the host side of a serial flash and fetches a fixed-length burst of bytes with a fast-read command. A one-cycle start request carries a 24-bit byte address and a two-bit lane mode. The block then drives chip select, the serial clock and four data lines, each line with its own output enable. Read bytes come back on a valid/ready stream. A done pulse marks the end of the burst.

The lane width changes from phase to phase. The command byte always goes out on lane 0 alone. The address goes out on one, two or four lanes, depending on the mode. A phase of mode bits and/or idle clocks follows the address. The read data comes back on two or four lanes. The lane mode selects the command byte. When the byte stream backs up, the serial clock is held, so no read data is lost.

Top module: `flash_fastread_ctrl`

## Requirements
- R1: The command byte depends on `mode_i`: 0 (dual-lane data) sends 0x3B, 1 (dual-lane address and data) sends 0xBB, 2 (quad-lane data) sends 0x6B, 3 (quad-lane address and data) sends 0xEB. It is shifted out most significant bit first on lane 0 only, over 8 clocks.
- R2: The 24-bit address follows, most significant bit first. It takes 1 lane in modes 0 and 2, 2 lanes in mode 1 and 4 lanes in mode 3. In each clock the highest-numbered lane carries the highest bit of the group.
- R3: With default parameters, the number of serial clocks in one burst is 168, 152, 104 or 84 for modes 0 to 3. These counts are built from 8 command clocks, the address clocks, the mode-bit clocks (0, 4, 0, 2), the idle clocks (8, 0, 8, 4) and the data clocks (128, 128, 64, 64).
- R4: During the mode-bit clocks, the address lanes stay enabled and carry 0.
- R5: The output enables are 0001 during the command, the address-lane mask during the address and the mode bits, and 0000 during the idle clocks and the whole data phase.
- R6: Read data is sampled on rising serial clock edges. Data comes most significant bit first, with the highest lane holding the highest bit of each group. Exactly BURST_BYTES bytes (default 32) are delivered in address order, and each byte is held stable while valid is high and ready is low.
- R7: The bus follows SPI mode 0. The clock is low whenever chip select is high. Chip select falls one system cycle before the first rising edge. Every high clock phase lasts one system cycle. Chip select rises only after the clock has been low for at least one cycle.
- R8: When a data clock is due and a byte is waiting with ready low, the serial clock stays low. No byte is dropped or overwritten.
- R9: A start request is ignored while a burst is in progress. The address and mode of the running burst do not change, and no second burst follows.
- R10: `busy_o` is high from the cycle after an accepted start until the burst ends. `done_o` pulses for one cycle, in the cycle after chip select returns high. Chip select stays high while the block is not busy.
- R11: After reset, chip select is high, the clock is low, all enables are 0, and valid, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request, sampled while idle |
| addr_i | input | 24 | Start byte address |
| mode_i | input | 2 | Lane mode, encoded as in R1 |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock, half the system rate |
| io_out_o | output | 4 | Data line output values |
| io_oe_o | output | 4 | Per-lane output enables |
| io_in_i | input | 4 | Data line input values |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | Consumer accepts the read byte |

## Verification
A behavioural flash model on the bench decodes each burst on its own. It recovers the command and the address, counts the serial clocks, and checks the enables and the mode-bit lanes in every phase. It then returns a byte pattern derived from the address, which a scoreboard compares byte by byte. All four lane modes are exercised under three consumer patterns:
- With the consumer always ready, the runs separate the four command, address and clock-count tables.
- With a pseudo-random ready, each byte has to be held and the clock stalled at irregular points.
- With long ready-low windows, a missing clock hold shows up as lost or overwritten bytes.

Stray start requests in the middle of a burst, with a different address and mode, check that the running burst is left untouched. An address near the top of the space checks that the returned data follows the start address.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [1:0] {
    RD_DUAL_OUT = 2'd0,
    RD_DUAL_IO  = 2'd1,
    RD_QUAD_OUT = 2'd2,
    RD_QUAD_IO  = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    PH_OPC   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_MODEB = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  function automatic logic [7:0] opcode_of(rd_mode_e m);
    case (m)
      RD_DUAL_IO:  return 8'hBB;
      RD_QUAD_OUT: return 8'h6B;
      RD_QUAD_IO:  return 8'hEB;
      default:     return 8'h3B;
    endcase
  endfunction

  // lanes carrying the address (and the mode bits)
  function automatic logic [3:0] addr_mask(rd_mode_e m);
    case (m)
      RD_DUAL_IO: return 4'b0011;
      RD_QUAD_IO: return 4'b1111;
      default:    return 4'b0001;
    endcase
  endfunction

  function automatic logic data_quad(rd_mode_e m);
    return (m == RD_QUAD_OUT) || (m == RD_QUAD_IO);
  endfunction

  // enables driven while the clock of phase ph runs
  function automatic logic [3:0] launch_mask(phase_e ph, rd_mode_e m);
    case (ph)
      PH_OPC:            return 4'b0001;
      PH_ADDR, PH_MODEB: return addr_mask(m);
      default:           return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
  import flash_rd_pkg::*;
#(
  parameter int BURST_BYTES  = 32,
  parameter int DUMMY_OUT    = 8,
  parameter int MODE_CLK_DIO = 4,
  parameter int DUMMY_DIO    = 0,
  parameter int MODE_CLK_QIO = 2,
  parameter int DUMMY_QIO    = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  rd_mode_e mode_i,
  input  logic     stall_i,
  input  logic     drain_ok_i,
  output logic     cs_n_o,
  output logic     sck_o,
  output logic     busy_o,
  output logic     done_o,
  output logic     load_o,
  output logic     launch_o,
  output logic     sample_o,
  output logic     data_clk_pending_o,
  output phase_e   launch_ph_o,
  output phase_e   phase_o,
  output rd_mode_e mode_o
);

  localparam int CNT_W = $clog2(BURST_BYTES * 4 + 64);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL, S_END} seq_state_e;

  function automatic int unsigned ph_len(phase_e p, rd_mode_e m);
    case (p)
      PH_OPC:   return 8;
      PH_ADDR:  return (m == RD_QUAD_IO) ? 6 : (m == RD_DUAL_IO) ? 12 : 24;
      PH_MODEB: return (m == RD_DUAL_IO) ? MODE_CLK_DIO :
                       (m == RD_QUAD_IO) ? MODE_CLK_QIO : 0;
      PH_DUMMY: return (m == RD_DUAL_IO) ? DUMMY_DIO :
                       (m == RD_QUAD_IO) ? DUMMY_QIO : DUMMY_OUT;
      default:  return data_quad(m) ? BURST_BYTES * 2 : BURST_BYTES * 4;
    endcase
  endfunction

  seq_state_e       state_q;
  logic             sck_q, cs_n_q, done_q;
  phase_e           phase_q, nxt_ph;
  rd_mode_e         mode_q;
  logic [CNT_W-1:0] left_q;
  logic             stall, rise, fall, last;

  // next phase with a non-zero clock count
  always_comb begin
    nxt_ph = PH_DATA;
    for (int k = 4; k >= 1; k--) begin
      if (int'(phase_q) + k <= 4) begin
        if (ph_len(phase_e'(3'(int'(phase_q) + k)), mode_q) != 0)
          nxt_ph = phase_e'(3'(int'(phase_q) + k));
      end
    end
  end

  assign stall    = (phase_q == PH_DATA) && stall_i;
  assign rise     = (state_q == S_SHIFT) && !sck_q && !stall;
  assign fall     = (state_q == S_SHIFT) && sck_q;
  assign last     = (left_q == CNT_W'(1));
  assign load_o   = (state_q == S_IDLE) && start_i;
  assign launch_o = load_o || (fall && !(last && phase_q == PH_DATA));
  assign sample_o = rise;
  assign data_clk_pending_o = (state_q == S_SHIFT) && !sck_q && (phase_q == PH_DATA);
  assign launch_ph_o = (state_q == S_IDLE) ? PH_OPC : (last ? nxt_ph : phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      phase_q <= PH_OPC;
      mode_q  <= RD_DUAL_OUT;
      left_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_SHIFT;
          cs_n_q  <= 1'b0;
          mode_q  <= mode_i;
          phase_q <= PH_OPC;
          left_q  <= CNT_W'(8);
        end
        S_SHIFT: begin
          if (rise) begin
            sck_q <= 1'b1;
          end else if (fall) begin
            sck_q <= 1'b0;
            if (last) begin
              if (phase_q == PH_DATA) begin
                state_q <= S_TAIL;
              end else begin
                phase_q <= nxt_ph;
                left_q  <= CNT_W'(ph_len(nxt_ph, mode_q));
              end
            end else begin
              left_q <= left_q - CNT_W'(1);
            end
          end
        end
        S_TAIL: if (drain_ok_i) begin
          cs_n_q  <= 1'b1;
          state_q <= S_END;
        end
        default: begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
      endcase
    end
  end

  assign cs_n_o  = cs_n_q;
  assign sck_o   = sck_q;
  assign done_o  = done_q;
  assign busy_o  = (state_q != S_IDLE);
  assign phase_o = phase_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/flash_rd_tx.sv
module flash_rd_tx
  import flash_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic        launch_i,
  input  rd_mode_e    mode_i,
  input  logic [23:0] addr_i,
  input  logic [3:0]  mask_i,
  output logic [3:0]  io_out_o,
  output logic [3:0]  io_oe_o
);

  logic [39:0] sr_q, src;

  // command, address, then a zero byte for the mode bits
  assign src = load_i ? {opcode_of(mode_i), addr_i, 8'h00} : sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      io_out_o <= '0;
      io_oe_o  <= '0;
    end else if (launch_i) begin
      io_oe_o <= mask_i;
      case (mask_i)
        4'b0001: begin io_out_o <= {3'b000, src[39]};   sr_q <= src << 1; end
        4'b0011: begin io_out_o <= {2'b00, src[39:38]}; sr_q <= src << 2; end
        4'b1111: begin io_out_o <= src[39:36];          sr_q <= src << 4; end
        default: begin io_out_o <= 4'b0000;             sr_q <= src;      end
      endcase
    end
  end

endmodule

// File: rtl/flash_rd_rx.sv
module flash_rd_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       sample_i,
  input  logic       quad_i,
  input  logic [3:0] io_in_i,
  input  logic       ready_i,
  output logic [7:0] data_o,
  output logic       valid_o
);

  logic [7:0] acc_q, merged;
  logic [2:0] cnt_q;
  logic       complete;

  assign merged   = quad_i ? {acc_q[3:0], io_in_i} : {acc_q[5:0], io_in_i[1:0]};
  assign complete = quad_i ? (cnt_q == 3'd4) : (cnt_q == 3'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (clear_i) begin
        cnt_q <= '0;
      end else if (sample_i) begin
        acc_q <= merged;
        cnt_q <= complete ? 3'd0 : cnt_q + (quad_i ? 3'd4 : 3'd2);
      end
      if (sample_i && !clear_i && complete) begin
        data_o  <= merged;
        valid_o <= 1'b1;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/flash_fastread_ctrl.sv
module flash_fastread_ctrl
  import flash_rd_pkg::*;
#(
  parameter int BURST_BYTES  = 32,
  parameter int DUMMY_OUT    = 8,
  parameter int MODE_CLK_DIO = 4,
  parameter int DUMMY_DIO    = 0,
  parameter int MODE_CLK_QIO = 2,
  parameter int DUMMY_QIO    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [23:0] addr_i,
  input  logic [1:0]  mode_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        cs_n_o,
  output logic        sck_o,
  output logic [3:0]  io_out_o,
  output logic [3:0]  io_oe_o,
  input  logic [3:0]  io_in_i,
  output logic [7:0]  rd_data_o,
  output logic        rd_valid_o,
  input  logic        rd_ready_i
);

  rd_mode_e mode_in, mode_q;
  phase_e   launch_ph, phase_q;
  logic     load, launch, sample, data_clk_pending;
  logic     stall, drain_ok;

  assign mode_in  = rd_mode_e'(mode_i);
  assign stall    = rd_valid_o && !rd_ready_i;
  assign drain_ok = !rd_valid_o || rd_ready_i;

  flash_rd_seq #(
    .BURST_BYTES(BURST_BYTES), .DUMMY_OUT(DUMMY_OUT),
    .MODE_CLK_DIO(MODE_CLK_DIO), .DUMMY_DIO(DUMMY_DIO),
    .MODE_CLK_QIO(MODE_CLK_QIO), .DUMMY_QIO(DUMMY_QIO)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_in),
    .stall_i(stall), .drain_ok_i(drain_ok),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .busy_o(busy_o), .done_o(done_o),
    .load_o(load), .launch_o(launch), .sample_o(sample),
    .data_clk_pending_o(data_clk_pending),
    .launch_ph_o(launch_ph), .phase_o(phase_q), .mode_o(mode_q)
  );

  flash_rd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(load), .launch_i(launch),
    .mode_i(mode_in), .addr_i(addr_i),
    .mask_i(launch_mask(launch_ph, mode_q)),
    .io_out_o(io_out_o), .io_oe_o(io_oe_o)
  );

  flash_rd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clear_i(load),
    .sample_i(sample && (phase_q == PH_DATA)),
    .quad_i(data_quad(mode_q)), .io_in_i(io_in_i), .ready_i(rd_ready_i),
    .data_o(rd_data_o), .valid_o(rd_valid_o)
  );

endmodule

// File: rtl/flash_rd_checker.sv
module flash_rd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       done,
  input logic       busy,
  input logic [3:0] io_oe,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       data_clk_pending
);

  a_r7_clk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r7_high_phase_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck);

  a_r5_lanes_released_for_data: assert property (@(posedge clk) disable iff (!rst_n)
    data_clk_pending |-> (io_oe == 4'b0000));

  a_r8_clock_held_on_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    data_clk_pending && rd_valid && !rd_ready |=> !sck);

  a_r6_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  a_r10_done_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && $past(cs_n));

  a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

endmodule

bind flash_fastread_ctrl flash_rd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n_o), .sck(sck_o), .done(done_o),
  .busy(busy_o), .io_oe(io_oe_o), .rd_valid(rd_valid_o), .rd_ready(rd_ready_i),
  .rd_data(rd_data_o), .data_clk_pending(data_clk_pending)
);

// File: tb/tb_flash_fastread_ctrl.sv
`timescale 1ns/1ps
module tb_flash_fastread_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [1:0]  mode_i = '0;
  logic        busy_o, done_o, cs_n_o, sck_o, rd_valid_o;
  logic [3:0]  io_out_o, io_oe_o;
  logic [3:0]  io_in_i = '0;
  logic [7:0]  rd_data_o;
  logic        rd_ready_i = 1'b1;

  always #2.5 clk = ~clk;

  flash_fastread_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .mode_i(mode_i),
    .busy_o(busy_o), .done_o(done_o), .cs_n_o(cs_n_o), .sck_o(sck_o),
    .io_out_o(io_out_o), .io_oe_o(io_oe_o), .io_in_i(io_in_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected tables written from the requirements
  function automatic int aw_of(int m); return (m == 1) ? 2 : (m == 3) ? 4 : 1; endfunction
  function automatic int dw_of(int m); return (m >= 2) ? 4 : 2; endfunction
  function automatic int mb_of(int m); return (m == 1) ? 4 : (m == 3) ? 2 : 0; endfunction
  function automatic int dm_of(int m); return (m == 1) ? 0 : (m == 3) ? 4 : 8; endfunction
  function automatic int op_of(int m);
    return (m == 0) ? 'h3B : (m == 1) ? 'hBB : (m == 2) ? 'h6B : 'hEB;
  endfunction
  function automatic int total_of(int m);
    return (m == 0) ? 168 : (m == 1) ? 152 : (m == 2) ? 104 : 84;
  endfunction
  function automatic logic [3:0] msk(int w);
    return (w == 1) ? 4'b0001 : (w == 2) ? 4'b0011 : 4'b1111;
  endfunction
  function automatic logic [7:0] pat(logic [23:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h3C;
  endfunction

  int          cur_mode = 0;
  logic [23:0] cur_addr = '0;
  logic [7:0]  exp_q[$];
  int          ready_style = 0;
  int          done_cnt = 0;

  // flash model
  int          ck;
  logic [7:0]  m_opc;
  logic [23:0] m_addr;
  bit          oe_err, mb_err;

  always @(negedge cs_n_o or posedge sck_o) begin
    int aend, mend;
    if (!sck_o) begin
      ck = 0; m_opc = '0; m_addr = '0; oe_err = 0; mb_err = 0;
    end else begin
      aend = 8 + 24 / aw_of(cur_mode);
      mend = aend + mb_of(cur_mode);
      if (ck < 8) begin
        m_opc = {m_opc[6:0], io_out_o[0]};
        if (io_oe_o != 4'b0001) oe_err = 1;
      end else if (ck < aend) begin
        for (int b = aw_of(cur_mode) - 1; b >= 0; b--) m_addr = {m_addr[22:0], io_out_o[b]};
        if (io_oe_o != msk(aw_of(cur_mode))) oe_err = 1;
      end else if (ck < mend) begin
        if (io_oe_o != msk(aw_of(cur_mode))) oe_err = 1;
        if ((io_out_o & msk(aw_of(cur_mode))) != 4'b0000) mb_err = 1;
      end else if (io_oe_o != 4'b0000) begin
        oe_err = 1;
      end
      ck++;
    end
  end

  always @(negedge sck_o) begin
    int ds, j, dw, pos;
    logic [7:0] bv;
    if (!cs_n_o) begin
      dw = dw_of(cur_mode);
      ds = 8 + 24 / aw_of(cur_mode) + mb_of(cur_mode) + dm_of(cur_mode);
      if (ck >= ds) begin
        j   = ck - ds;
        pos = (j * dw) % 8;
        bv  = pat(24'(cur_addr + 24'(j * dw / 8)));
        io_in_i = 4'((bv >> (8 - pos - dw))) & msk(dw);
      end
    end
  end

  always @(posedge cs_n_o) begin
    if (rst_n) begin
      check(m_opc == 8'(op_of(cur_mode)), "R1 opcode", m_opc, op_of(cur_mode));
      check(m_addr == cur_addr, "R2 address", m_addr, cur_addr);
      check(ck == total_of(cur_mode), "R3 clock count", ck, total_of(cur_mode));
      check(!mb_err, "R4 mode bits zero", mb_err, 0);
      check(!oe_err, "R5 output enables", oe_err, 0);
    end
  end

  // monitor, ready driver and scoreboard
  logic [15:0] lfsr = 16'hACE1;
  int  cyc = 0, cs_fall_cyc = 0;
  bit  prev_cs = 1, prev_sck = 0, rise_pending = 0;

  always @(negedge clk) begin
    logic [7:0] e;
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_style)
      1:       rd_ready_i = lfsr[0] | lfsr[3];
      2:       rd_ready_i = (cyc % 50) >= 40;
      default: rd_ready_i = 1'b1;
    endcase
    if (rst_n) begin
      if (rd_valid_o && rd_ready_i) begin
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected byte", rd_data_o, 0);
        end else begin
          e = exp_q.pop_front();
          check(rd_data_o == e, "R6 R8 read byte", rd_data_o, e);
        end
      end
      if (prev_cs && !cs_n_o) begin cs_fall_cyc = cyc; rise_pending = 1; end
      if (rise_pending && sck_o) begin
        check(cyc - cs_fall_cyc == 1, "R7 select lead", cyc - cs_fall_cyc, 1);
        rise_pending = 0;
      end
      if (!prev_cs && cs_n_o) check(!prev_sck && !sck_o, "R7 select trail", prev_sck, 0);
      if (done_o) begin
        done_cnt++;
        check(cs_n_o && prev_cs, "R10 done after deselect", cs_n_o, 1);
      end
    end
    prev_cs  = cs_n_o;
    prev_sck = sck_o;
  end

  task automatic run_burst(int m, logic [23:0] a, int style, bit poke);
    int d0, guard;
    ready_style = style;
    cur_mode = m;
    cur_addr = a;
    for (int k = 0; k < 32; k++) exp_q.push_back(pat(24'(a + 24'(k))));
    d0 = done_cnt;
    @(negedge clk);
    start_i = 1'b1; addr_i = a; mode_i = 2'(m);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1; addr_i = ~a; mode_i = 2'(m + 1);
      @(negedge clk);
      start_i = 1'b0;
      repeat (30) @(negedge clk);
      start_i = 1'b1; addr_i = a ^ 24'h00F0F0; mode_i = 2'(m + 2);
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (done_cnt == d0 && guard < 8000) begin @(negedge clk); guard++; end
    check(done_cnt == d0 + 1, "R10 done pulse", done_cnt - d0, 1);
    check(exp_q.size() == 0, "R6 byte count", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(!done_o && !busy_o, "R10 done one cycle", done_o, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      check(cs_n_o && !busy_o, "R9 no second burst", cs_n_o, 1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n_o == 1'b1, "R11 cs", cs_n_o, 1);
    check(sck_o == 1'b0, "R11 sck", sck_o, 0);
    check(io_oe_o == 4'b0000, "R11 enables", io_oe_o, 0);
    check(!rd_valid_o && !busy_o && !done_o, "R11 flags", {rd_valid_o, busy_o, done_o}, 0);
    for (int m = 0; m < 4; m++) run_burst(m, 24'h12_3456 + 24'(m * 'h111), 0, 0);
    for (int m = 0; m < 4; m++) run_burst(m, 24'hA5_C396 ^ 24'(m * 'h0F0F), 1, 0);
    run_burst(0, 24'h00_0040, 2, 0);
    run_burst(3, 24'h7E_81C0, 2, 0);
    run_burst(1, 24'h55_AA33, 0, 1);
    run_burst(2, 24'h0B_EEF0, 1, 1);
    run_burst(3, 24'hFF_FFF8, 0, 0);
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule